// File: doc/BRIEF.md
# Latched-Request Priority Interrupt Controller

This block gathers up to N interrupt request lines into one interrupt output for a processor. Every request, whether a short pulse or a held level, is caught in a sticky pending register. A mask register keeps chosen sources out of arbitration. Among the unmasked pending sources, an arbiter selects exactly one. The selection is written into a separate one-hot in-service register, which drives the interrupt line.

The arbiter has a programmable start position. The search begins at that index and moves upward, wrapping round. With a start position of zero this is fixed lowest-index-first priority. Software reads an index register to learn which source was selected. It then clears the pending bit and afterwards the in-service bit, both by writing ones. No new selection is made while an in-service bit is set. Requests that arrive during service only set their pending bits, and they are arbitrated as soon as the in-service register is cleared.

The host reaches the registers over a simple word-addressed register bus with write and read strobes. Read data is registered.

Top module: `prio_irq_ctrl`

## Requirements
- R1: After reset the pending register reads 0, the mask register reads all ones (every source masked), the in-service register reads 0, the start position reads 0 and irq is low.
- R2: A request bit that is high at a clock edge sets its pending bit (address 0) at that edge. The bit stays set until software clears it, whatever the request does afterwards.
- R3: Writing to address 0 (pending) or address 2 (in-service) clears each bit written as 1 and leaves each bit written as 0 unchanged. If a request is high in the same cycle as a clear of its pending bit, the bit stays set.
- R4: While the in-service register is zero, the next edge sets in it the bit of one unmasked pending source. Mask bits are at address 1, and a mask bit of 1 excludes that source. The chosen source is the first unmasked pending index found when searching upward from the start position (address 4, bits [IW-1:0]) and wrapping past N-1 to 0. Masked or absent sources never cause a selection.
- R5: At most one bit of the in-service register is ever set.
- R6: While an in-service bit is set it stays unchanged until software clears it, and new requests only set pending bits. After it is cleared, arbitration resumes at the next edge. A source whose pending bit was left set is selected again.
- R7: Address 3 reads the index of the set in-service bit, zero-extended. It reads 0 when the in-service register is zero.
- R8: irq is high exactly when the in-service register is nonzero.
- R9: A read strobe captures the addressed register into rd_data at the clock edge, and rd_data holds its value between reads. Writes to address 3 have no effect.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req | input | N | Interrupt request lines, level or pulse |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe |
| addr | input | AW | Register word address |
| wdata | input | DW | Write data |
| rd_data | output | DW | Registered read data |
| irq | output | 1 | Interrupt output to the processor |

## Verification
The hardest case to reach is the wrap-around of the rotating search. It only shows when several unmasked sources wait on both sides of the start position while another source is still in service. The stimulus builds this up by pulsing requests during service, widening the mask, and moving the start position past the lower pending indices, all before the in-service bit is released. It then walks through the successive selections one at a time. A held request is also driven in the same cycle as a write-one-clear of its own bit, to show that the set takes precedence.

// File: rtl/pic_pkg.sv
package pic_pkg;
    typedef enum logic [2:0] {
        REG_PEND   = 3'd0,
        REG_MASK   = 3'd1,
        REG_INSVC  = 3'd2,
        REG_OFFSET = 3'd3,
        REG_BASE   = 3'd4
    } pic_reg_e;
endpackage

// File: rtl/pic_arbiter.sv
module pic_arbiter #(
    parameter int N  = 32,
    parameter int IW = 5
) (
    input  logic [N-1:0]  cand,
    input  logic [IW-1:0] start,
    output logic [N-1:0]  grant,
    output logic          any
);
    always_comb begin
        logic found;
        found = 1'b0;
        grant = '0;
        for (int k = 0; k < N; k++) begin
            int pos;
            pos = int'(start) + k;
            if (pos >= N) pos = pos - N;
            if (!found && cand[pos]) begin
                grant[pos] = 1'b1;
                found      = 1'b1;
            end
        end
        any = found;
    end
endmodule

// File: rtl/pic_encoder.sv
module pic_encoder #(
    parameter int N  = 32,
    parameter int IW = 5
) (
    input  logic [N-1:0]  onehot,
    output logic [IW-1:0] index
);
    always_comb begin
        index = '0;
        for (int i = 0; i < N; i++) begin
            if (onehot[i]) index = index | IW'(i);
        end
    end
endmodule

// File: rtl/prio_irq_ctrl.sv
module prio_irq_ctrl
    import pic_pkg::*;
#(
    parameter int N  = 32,
    parameter int DW = 32,
    parameter int AW = 3
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [N-1:0]  req,
    input  logic          wr_en,
    input  logic          rd_en,
    input  logic [AW-1:0] addr,
    input  logic [DW-1:0] wdata,
    output logic [DW-1:0] rd_data,
    output logic          irq
);
    localparam int IW = (N > 1) ? $clog2(N) : 1;

    typedef struct packed {
        logic [N-1:0]  pend;
        logic [N-1:0]  mask;
        logic [N-1:0]  insvc;
        logic [IW-1:0] start;
        logic [DW-1:0] rdata;
    } state_t;

    state_t st_d, st_q;

    logic [N-1:0]  pend_q, mask_q, insvc_q;
    logic [N-1:0]  grant;
    logic          grant_any;
    logic [IW-1:0] sel_index;

    assign pend_q  = st_q.pend;
    assign mask_q  = st_q.mask;
    assign insvc_q = st_q.insvc;

    pic_arbiter #(.N(N), .IW(IW)) u_arb (
        .cand  (st_q.pend & ~st_q.mask),
        .start (st_q.start),
        .grant (grant),
        .any   (grant_any)
    );

    pic_encoder #(.N(N), .IW(IW)) u_enc (
        .onehot (st_q.insvc),
        .index  (sel_index)
    );

    always_comb begin
        logic          wr_pend, wr_mask, wr_insvc, wr_start;
        logic [N-1:0]  wbits;
        logic [IW-1:0] wstart;

        st_d     = st_q;
        wbits    = wdata[N-1:0];
        wstart   = wdata[IW-1:0];
        wr_pend  = wr_en && (addr == AW'(REG_PEND));
        wr_mask  = wr_en && (addr == AW'(REG_MASK));
        wr_insvc = wr_en && (addr == AW'(REG_INSVC));
        wr_start = wr_en && (addr == AW'(REG_BASE));

        // pending: clear by write-one, new request has precedence
        st_d.pend = (wr_pend ? (st_q.pend & ~wbits) : st_q.pend) | req;

        if (wr_mask) st_d.mask = wbits;

        if (wr_start) st_d.start = (int'(wstart) < N) ? wstart : '0;

        // in-service: hold while set, select when empty
        if (st_q.insvc != '0) begin
            if (wr_insvc) st_d.insvc = st_q.insvc & ~wbits;
        end else if (grant_any) begin
            st_d.insvc = grant;
        end

        if (rd_en) begin
            case (addr)
                AW'(REG_PEND):   st_d.rdata = DW'(st_q.pend);
                AW'(REG_MASK):   st_d.rdata = DW'(st_q.mask);
                AW'(REG_INSVC):  st_d.rdata = DW'(st_q.insvc);
                AW'(REG_OFFSET): st_d.rdata = DW'(sel_index);
                AW'(REG_BASE):   st_d.rdata = DW'(st_q.start);
                default:         st_d.rdata = '0;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.pend  <= '0;
            st_q.mask  <= '1;
            st_q.insvc <= '0;
            st_q.start <= '0;
            st_q.rdata <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign rd_data = st_q.rdata;
    assign irq     = |st_q.insvc;
endmodule

// File: rtl/prio_irq_ctrl_chk.sv
module prio_irq_ctrl_chk
    import pic_pkg::*;
#(
    parameter int N  = 32,
    parameter int DW = 32,
    parameter int AW = 3
) (
    input logic          clk,
    input logic          rst_n,
    input logic [N-1:0]  req,
    input logic          wr_en,
    input logic [AW-1:0] addr,
    input logic [DW-1:0] wdata,
    input logic          irq,
    input logic [N-1:0]  pend_q,
    input logic [N-1:0]  mask_q,
    input logic [N-1:0]  insvc_q
);
    // R2: every sampled request is present in pending afterwards
    a_r2_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ((pend_q & $past(req)) == $past(req)));

    // R3: zero bits of a pending write leave set bits alone
    a_r3_zero_keeps: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && addr == AW'(REG_PEND)) |=>
        (($past(pend_q & ~wdata[N-1:0]) & ~pend_q) == '0));

    // R4: a selection is one of the unmasked pending sources
    a_r4_pick_valid: assert property (@(posedge clk) disable iff (!rst_n)
        (insvc_q == '0 && (pend_q & ~mask_q) != '0) |=>
        (insvc_q != '0 && (insvc_q & ~$past(pend_q & ~mask_q)) == '0));

    // R4: no candidates, no selection
    a_r4_no_pick: assert property (@(posedge clk) disable iff (!rst_n)
        (insvc_q == '0 && (pend_q & ~mask_q) == '0) |=> (insvc_q == '0));

    // R5
    a_r5_onehot: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(insvc_q));

    // R6: selection held until a write-one hits it
    a_r6_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (insvc_q != '0 &&
         !(wr_en && addr == AW'(REG_INSVC) && (wdata[N-1:0] & insvc_q) != '0))
        |=> (insvc_q == $past(insvc_q)));

    // R8
    a_r8_irq_sel: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> $onehot(insvc_q));

    a_r8_irq_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        !irq |-> (insvc_q == '0));
endmodule

bind prio_irq_ctrl prio_irq_ctrl_chk #(.N(N), .DW(DW), .AW(AW)) u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .req     (req),
    .wr_en   (wr_en),
    .addr    (addr),
    .wdata   (wdata),
    .irq     (irq),
    .pend_q  (pend_q),
    .mask_q  (mask_q),
    .insvc_q (insvc_q)
);

// File: tb/prio_irq_ctrl_test.sv
module prio_irq_ctrl_test;
    localparam int N = 32;
    localparam int DW = 32;
    localparam int AW = 3;
    localparam int CLK_PERIOD = 10;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [N-1:0]  req = '0;
    logic          wr_en = 1'b0;
    logic          rd_en = 1'b0;
    logic [AW-1:0] addr = '0;
    logic [DW-1:0] wdata = '0;
    logic [DW-1:0] rd_data;
    logic          irq;

    int tests = 0;
    int fails = 0;
    bit done = 0;

    // reference model state
    logic [N-1:0]  m_pend, m_mask, m_insvc;
    int            m_start;
    logic [DW-1:0] m_rdata;

    always #(CLK_PERIOD/2) clk = ~clk;

    prio_irq_ctrl #(.N(N), .DW(DW), .AW(AW)) uut (
        .clk(clk), .rst_n(rst_n), .req(req), .wr_en(wr_en), .rd_en(rd_en),
        .addr(addr), .wdata(wdata), .rd_data(rd_data), .irq(irq)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    function automatic int sel_idx(input logic [N-1:0] v);
        for (int i = 0; i < N; i++) if (v[i]) return i;
        return 0;
    endfunction

    task automatic tick();
        logic [N-1:0]  np, nm, ni;
        int            ns;
        logic [DW-1:0] nr;
        np = m_pend; nm = m_mask; ni = m_insvc; ns = m_start; nr = m_rdata;
        if (rst_n) begin
            if (wr_en && addr == 3'd0) np = np & ~wdata;
            np = np | req;
            if (wr_en && addr == 3'd1) nm = wdata;
            if (wr_en && addr == 3'd4) ns = int'(wdata[4:0]);
            if (m_insvc != 0) begin
                if (wr_en && addr == 3'd2) ni = m_insvc & ~wdata;
            end else begin
                for (int k = 0; k < N; k++) begin
                    int p;
                    p = (m_start + k) % N;
                    if (ni == 0 && m_pend[p] && !m_mask[p]) ni[p] = 1'b1;
                end
            end
            if (rd_en) begin
                case (addr)
                    3'd0: nr = m_pend;
                    3'd1: nr = m_mask;
                    3'd2: nr = m_insvc;
                    3'd3: nr = sel_idx(m_insvc);
                    3'd4: nr = m_start;
                    default: nr = 0;
                endcase
            end
        end
        @(posedge clk);
        m_pend = np; m_mask = nm; m_insvc = ni; m_start = ns; m_rdata = nr;
        #2;
        chk("R8 irq vs model", irq, (m_insvc != 0));
        chk("R9 rd_data vs model", rd_data, m_rdata);
    endtask

    task automatic wr(input logic [AW-1:0] a, input logic [DW-1:0] d);
        wr_en = 1'b1; addr = a; wdata = d;
        tick();
        wr_en = 1'b0; wdata = '0;
    endtask

    task automatic rd(input logic [AW-1:0] a, output logic [DW-1:0] d);
        rd_en = 1'b1; addr = a;
        tick();
        rd_en = 1'b0;
        d = rd_data;
    endtask

    task automatic pulse(input logic [N-1:0] r);
        req = r;
        tick();
        req = '0;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            fails++;
            tests++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

    initial begin
        logic [DW-1:0] v;
        m_pend = '0; m_mask = '1; m_insvc = '0; m_start = 0; m_rdata = '0;
        repeat (3) @(posedge clk);
        #2;
        rst_n = 1'b1;

        // R1 reset state
        rd(3'd0, v); chk("R1 pend after reset", v, 32'h0);
        rd(3'd1, v); chk("R1 mask after reset", v, 32'hFFFF_FFFF);
        rd(3'd2, v); chk("R1 insvc after reset", v, 32'h0);
        rd(3'd4, v); chk("R1 start after reset", v, 32'h0);
        chk("R1 irq after reset", irq, 1'b0);

        // R2 pulses latched; all masked so nothing selected
        pulse(32'h0000_0208);
        tick(); tick();
        rd(3'd0, v); chk("R2 pend latched", v, 32'h0000_0208);
        chk("R4 masked no irq", irq, 1'b0);

        // R4 unmask 3, 9, 20 -> lowest index 3 selected
        wr(3'd1, 32'hFFEF_FDF7);
        tick();
        rd(3'd2, v); chk("R4 insvc picks 3", v, 32'h0000_0008);
        rd(3'd3, v); chk("R7 offset 3", v, 32'd3);
        chk("R8 irq high", irq, 1'b1);

        // R6 request during service only pends
        pulse(32'h0010_0000);
        tick();
        rd(3'd0, v); chk("R6 pend gains 20", v, 32'h0010_0208);
        rd(3'd2, v); chk("R6 insvc unchanged", v, 32'h0000_0008);

        // R3 write-one-clear, zero bits untouched
        wr(3'd0, 32'h0000_0008);
        rd(3'd0, v); chk("R3 pend w1c", v, 32'h0010_0200);
        wr(3'd2, 32'h0000_0001);
        rd(3'd2, v); chk("R3 insvc zero bits keep", v, 32'h0000_0008);
        wr(3'd2, 32'h0000_0008);
        tick();
        rd(3'd3, v); chk("R6 next pick 9", v, 32'd9);

        // R4 wrap: pending 3,20,25; start 21
        pulse(32'h0200_0008);
        wr(3'd1, 32'hFDEF_FDF7);
        wr(3'd4, 32'd21);
        wr(3'd0, 32'h0000_0200);
        rd(3'd0, v); chk("R2 pend 3,20,25", v, 32'h0210_0008);
        wr(3'd2, 32'h0000_0200);
        tick();
        rd(3'd3, v); chk("R4 start 21 picks 25", v, 32'd25);
        wr(3'd0, 32'h0200_0000);
        wr(3'd2, 32'h0200_0000);
        tick();
        rd(3'd3, v); chk("R4 wrap picks 3", v, 32'd3);
        wr(3'd0, 32'h0000_0008);
        wr(3'd2, 32'h0000_0008);
        tick();
        rd(3'd3, v); chk("R4 then 20", v, 32'd20);

        // R6 uncleared pending re-raises
        wr(3'd2, 32'h0010_0000);
        tick();
        rd(3'd2, v); chk("R6 re-raise 20", v, 32'h0010_0000);

        // R3 set wins over simultaneous clear
        req = 32'h0010_0000;
        wr(3'd0, 32'h0010_0000);
        req = '0;
        rd(3'd0, v); chk("R3 set beats clear", v, 32'h0010_0000);
        wr(3'd0, 32'h0010_0000);
        wr(3'd2, 32'h0010_0000);
        tick();
        rd(3'd0, v); chk("R3 pend cleared", v, 32'h0);
        rd(3'd2, v); chk("R7 insvc empty", v, 32'h0);
        rd(3'd3, v); chk("R7 offset zero when idle", v, 32'd0);
        chk("R8 irq low idle", irq, 1'b0);

        // R9 offset register ignores writes; start holds
        wr(3'd3, 32'h0000_FFFF);
        rd(3'd3, v); chk("R9 offset read-only", v, 32'd0);
        rd(3'd4, v); chk("R9 start readback", v, 32'd21);
        tick(); tick();
        chk("R9 rd_data holds", rd_data, 32'd21);

        // R4 masked source 31 does not raise irq
        pulse(32'h8000_0000);
        tick(); tick();
        chk("R4 masked 31 no irq", irq, 1'b0);
        rd(3'd0, v); chk("R2 masked 31 pends", v, 32'h8000_0000);

        done = 1;
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule